// File: doc/BRIEF.md
# Host-Core Semaphore Register

This block holds one semaphore word that a host port and a core port share. Each bit has a single owner. The low field belongs to the host, and only a host write changes it. The high field belongs to the core, and only a core write changes it. Both ports always read the whole word. Software on the two sides uses the bits as ownership flags and handshake flags, with no arbitration beyond this per-bit ownership.

A small core-side control register goes with the word. It holds a sticky flag that records that the host has written the semaphore word, and an interrupt enable. The core clears the sticky flag by writing 1 to it. While the flag and the enable are both 1, a level interrupt to the core is high. Reads are combinational from the stored state. Writes take effect at the rising clock edge. The reset is synchronous and active high.

Top module: `hc_sema_reg`

## Requirements
- R1: After reset the semaphore word reads 0x00, the control register reads 0b00 and core_irq is 0.
- R2: A host write loads host_wr_data into word bits 3:0 at the next edge. Word bits 7:4 keep their value unless the core writes in the same cycle.
- R3: A core semaphore write loads core_sem_wr_data into word bits 7:4 at the next edge. Word bits 3:0 keep their value unless the host writes in the same cycle.
- R4: host_rd_data and sem_rd_data show the same 8-bit word in every cycle.
- R5: Any host write sets the sticky host-write flag (control bit 0) to 1 at the next edge, whatever data it carries.
- R6: A core control write with data bit 0 = 1 clears the sticky flag. With data bit 0 = 0 the flag keeps its value.
- R7: If a host write and a core control write with data bit 0 = 1 occur in the same cycle, the flag is 1 after the edge.
- R8: Control bit 1 is the interrupt enable. Every core control write loads it from data bit 1, and it keeps its value otherwise.
- R9: core_irq is 1 exactly when the sticky flag and the interrupt enable are both 1.
- R10: A host write and a core semaphore write in the same cycle both take effect, each on its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host write strobe for the semaphore word |
| host_wr_data | input | 4 | Value for the host-owned field |
| host_rd_data | output | 8 | Semaphore word as the host sees it |
| core_sem_wr_en | input | 1 | Core write strobe for the semaphore word |
| core_sem_wr_data | input | 4 | Value for the core-owned field |
| core_ctl_wr_en | input | 1 | Core write strobe for the control register |
| core_ctl_wr_data | input | 2 | Bit 0: 1 clears the flag. Bit 1: new enable |
| sem_rd_data | output | 8 | Semaphore word as the core sees it |
| ctl_rd_data | output | 2 | Bit 0: sticky flag. Bit 1: interrupt enable |
| core_irq | output | 1 | Level interrupt to the core |

## Verification
The assertions check on every cycle that each field changes only on a write by its owner and then takes the written value. They also check that both read ports agree, that a host write always leaves the flag set, that a clear with no host write leaves it reset, that the enable follows control writes, and that the interrupt is never high without the flag. The bench scenarios cover what a single-cycle property cannot show well. These are the reset values, a clear that collides with a host write, a write of 0 to the flag that leaves it set, and simultaneous writes by both sides, tracked across long random sequences against a model of the word.

// File: rtl/hc_sema_pkg.sv
package hc_sema_pkg;

    localparam int HOST_FIELD_W = 4;
    localparam int CORE_FIELD_W = 4;

    localparam int CTL_W        = 2;
    localparam int CTL_FLAG_POS = 0;
    localparam int CTL_IE_POS   = 1;

    typedef struct packed {
        logic ie;
        logic flag;
    } hc_ctl_t;

    localparam hc_ctl_t CTL_RESET = '{ie: 1'b0, flag: 1'b0};

    function automatic logic [CTL_W-1:0] ctl_pack(input hc_ctl_t c);
        logic [CTL_W-1:0] v;
        v = '0;
        v[CTL_FLAG_POS] = c.flag;
        v[CTL_IE_POS]   = c.ie;
        return v;
    endfunction

    function automatic logic flag_next(input logic cur, input logic set_req,
                                       input logic clr_req);
        logic n;
        n = cur;
        if (clr_req) n = 1'b0;
        if (set_req) n = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/hc_sema_field.sv
module hc_sema_field #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_val,
    output logic [FIELD_W-1:0] q
);
    logic [FIELD_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (wr_en) begin
            q_r <= wr_val;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/hc_sema_ctl.sv
module hc_sema_ctl
    import hc_sema_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_touch,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_val,
    output hc_ctl_t          ctl_q,
    output logic             irq
);
    hc_ctl_t cur_r;
    hc_ctl_t nxt;
    logic    clr_req;

    always_comb begin
        clr_req  = ctl_wr_en & ctl_wr_val[CTL_FLAG_POS];
        nxt      = cur_r;
        nxt.flag = flag_next(cur_r.flag, host_touch, clr_req);
        if (ctl_wr_en) begin
            nxt.ie = ctl_wr_val[CTL_IE_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_r <= CTL_RESET;
        end else begin
            cur_r <= nxt;
        end
    end

    assign ctl_q = cur_r;
    assign irq   = cur_r.flag & cur_r.ie;
endmodule

// File: rtl/hc_sema_reg.sv
module hc_sema_reg
    import hc_sema_pkg::*;
#(
    parameter int HOST_W = HOST_FIELD_W,
    parameter int CORE_W = CORE_FIELD_W,
    localparam int SEM_W = HOST_W + CORE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [HOST_W-1:0] host_wr_data,
    output logic [SEM_W-1:0]  host_rd_data,
    input  logic              core_sem_wr_en,
    input  logic [CORE_W-1:0] core_sem_wr_data,
    input  logic              core_ctl_wr_en,
    input  logic [CTL_W-1:0]  core_ctl_wr_data,
    output logic [SEM_W-1:0]  sem_rd_data,
    output logic [CTL_W-1:0]  ctl_rd_data,
    output logic              core_irq
);
    localparam int NUM_OWNERS = 2;

    logic [SEM_W-1:0] word;
    hc_ctl_t          ctl_state;

    generate
        for (genvar g = 0; g < NUM_OWNERS; g++) begin : g_owner
            if (g == 0) begin : g_host
                hc_sema_field #(.FIELD_W(HOST_W)) u_field (
                    .clk    (clk),
                    .rst    (rst),
                    .wr_en  (host_wr_en),
                    .wr_val (host_wr_data),
                    .q      (word[HOST_W-1:0])
                );
            end else begin : g_core
                hc_sema_field #(.FIELD_W(CORE_W)) u_field (
                    .clk    (clk),
                    .rst    (rst),
                    .wr_en  (core_sem_wr_en),
                    .wr_val (core_sem_wr_data),
                    .q      (word[SEM_W-1:HOST_W])
                );
            end
        end
    endgenerate

    hc_sema_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .host_touch (host_wr_en),
        .ctl_wr_en  (core_ctl_wr_en),
        .ctl_wr_val (core_ctl_wr_data),
        .ctl_q      (ctl_state),
        .irq        (core_irq)
    );

    assign host_rd_data = word;
    assign sem_rd_data  = word;
    assign ctl_rd_data  = ctl_pack(ctl_state);
endmodule

// File: rtl/hc_sema_reg_chk.sv
module hc_sema_reg_chk #(
    parameter int HOST_W = 4,
    parameter int CORE_W = 4,
    parameter int CTL_W  = 2,
    localparam int SEM_W = HOST_W + CORE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr_en,
    input logic [HOST_W-1:0] host_wr_data,
    input logic [SEM_W-1:0]  host_rd_data,
    input logic              core_sem_wr_en,
    input logic [CORE_W-1:0] core_sem_wr_data,
    input logic              core_ctl_wr_en,
    input logic [CTL_W-1:0]  core_ctl_wr_data,
    input logic [SEM_W-1:0]  sem_rd_data,
    input logic [CTL_W-1:0]  ctl_rd_data,
    input logic              core_irq
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sem_rd_data == '0 && ctl_rd_data == '0 && !core_irq));

    p_host_load_r2: assert property (@(posedge clk) disable iff (rst)
        host_wr_en |=> sem_rd_data[HOST_W-1:0] == $past(host_wr_data));

    p_core_field_kept_r2: assert property (@(posedge clk) disable iff (rst)
        !core_sem_wr_en |=> sem_rd_data[SEM_W-1:HOST_W] == $past(sem_rd_data[SEM_W-1:HOST_W]));

    p_core_load_r3: assert property (@(posedge clk) disable iff (rst)
        core_sem_wr_en |=> sem_rd_data[SEM_W-1:HOST_W] == $past(core_sem_wr_data));

    p_host_field_kept_r3: assert property (@(posedge clk) disable iff (rst)
        !host_wr_en |=> sem_rd_data[HOST_W-1:0] == $past(sem_rd_data[HOST_W-1:0]));

    p_same_view_r4: assert property (@(posedge clk) disable iff (rst)
        host_rd_data == sem_rd_data);

    p_flag_set_r5_r7: assert property (@(posedge clk) disable iff (rst)
        host_wr_en |=> ctl_rd_data[0]);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (core_ctl_wr_en && core_ctl_wr_data[0] && !host_wr_en) |=> !ctl_rd_data[0]);

    p_enable_load_r8: assert property (@(posedge clk) disable iff (rst)
        core_ctl_wr_en |=> ctl_rd_data[1] == $past(core_ctl_wr_data[1]));

    p_enable_kept_r8: assert property (@(posedge clk) disable iff (rst)
        !core_ctl_wr_en |=> $stable(ctl_rd_data[1]));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        core_irq |-> (ctl_rd_data[0] && ctl_rd_data[1]));
endmodule

bind hc_sema_reg hc_sema_reg_chk #(
    .HOST_W (HOST_W),
    .CORE_W (CORE_W),
    .CTL_W  (hc_sema_pkg::CTL_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .host_wr_en       (host_wr_en),
    .host_wr_data     (host_wr_data),
    .host_rd_data     (host_rd_data),
    .core_sem_wr_en   (core_sem_wr_en),
    .core_sem_wr_data (core_sem_wr_data),
    .core_ctl_wr_en   (core_ctl_wr_en),
    .core_ctl_wr_data (core_ctl_wr_data),
    .sem_rd_data      (sem_rd_data),
    .ctl_rd_data      (ctl_rd_data),
    .core_irq         (core_irq)
);

// File: tb/sim_hc_sema_reg.sv
`timescale 1ns/1ps
module sim_hc_sema_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr_en;
    logic [3:0] host_wr_data;
    logic [7:0] host_rd_data;
    logic       core_sem_wr_en;
    logic [3:0] core_sem_wr_data;
    logic       core_ctl_wr_en;
    logic [1:0] core_ctl_wr_data;
    logic [7:0] sem_rd_data;
    logic [1:0] ctl_rd_data;
    logic       core_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_sem;
    logic       m_flag;
    logic       m_ie;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_sema_reg u0 (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
        .core_sem_wr_en(core_sem_wr_en), .core_sem_wr_data(core_sem_wr_data),
        .core_ctl_wr_en(core_ctl_wr_en), .core_ctl_wr_data(core_ctl_wr_data),
        .sem_rd_data(sem_rd_data), .ctl_rd_data(ctl_rd_data), .core_irq(core_irq)
    );

    function automatic logic [7:0] f_sem(input logic [7:0] cur, input logic hw,
                                         input logic [3:0] hd, input logic cw,
                                         input logic [3:0] cd);
        logic [7:0] n;
        n = cur;
        if (hw) n[3:0] = hd;
        if (cw) n[7:4] = cd;
        return n;
    endfunction

    function automatic logic f_flag(input logic cur, input logic hw,
                                    input logic kw, input logic [1:0] kd);
        if (hw) return 1'b1;
        if (kw && kd[0]) return 1'b0;
        return cur;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R2/R3/R10 word"}, {24'd0, sem_rd_data}, {24'd0, m_sem});
        check({tag, " R4 host view"}, {24'd0, host_rd_data}, {24'd0, sem_rd_data});
        check({tag, " R5/R6/R7 flag"}, {31'd0, ctl_rd_data[0]}, {31'd0, m_flag});
        check({tag, " R8 enable"}, {31'd0, ctl_rd_data[1]}, {31'd0, m_ie});
        check({tag, " R9 irq"}, {31'd0, core_irq}, {31'd0, m_flag & m_ie});
    endtask

    task automatic step(input logic hw, input logic [3:0] hd, input logic cw,
                        input logic [3:0] cd, input logic kw, input logic [1:0] kd,
                        input string tag);
        @(negedge clk);
        host_wr_en = hw; host_wr_data = hd;
        core_sem_wr_en = cw; core_sem_wr_data = cd;
        core_ctl_wr_en = kw; core_ctl_wr_data = kd;
        @(posedge clk);
        #1;
        m_sem  = f_sem(m_sem, hw, hd, cw, cd);
        m_flag = f_flag(m_flag, hw, kw, kd);
        if (kw) m_ie = kd[1];
        check_all(tag);
    endtask

    initial begin
        int c;
        c = 0;
        while (!done && c < WATCHDOG) begin
            @(posedge clk);
            c++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EA7);
        rst = 1'b1;
        host_wr_en = 0; host_wr_data = 0;
        core_sem_wr_en = 0; core_sem_wr_data = 0;
        core_ctl_wr_en = 0; core_ctl_wr_data = 0;
        m_sem = 8'h00; m_flag = 0; m_ie = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset word", {24'd0, sem_rd_data}, 32'h0);
        check("R1 reset ctl", {30'd0, ctl_rd_data}, 32'h0);
        check("R1 reset irq", {31'd0, core_irq}, 32'h0);

        // R2: host field only, flag set (R5)
        step(1, 4'hA, 0, 4'h0, 0, 2'b00, "dir host");
        // R3: core field only
        step(0, 4'h0, 1, 4'h5, 0, 2'b00, "dir core");
        // R8: enable on, no clear -> R9 irq high
        step(0, 4'h0, 0, 4'h0, 1, 2'b10, "dir enable");
        check("R9 irq raised", {31'd0, core_irq}, 32'h1);
        // R6: write 0 to flag has no effect
        step(0, 4'h0, 0, 4'h0, 1, 2'b10, "dir w0");
        check("R6 write zero keeps flag", {31'd0, ctl_rd_data[0]}, 32'h1);
        // R6: write 1 clears
        step(0, 4'h0, 0, 4'h0, 1, 2'b11, "dir w1c");
        check("R6 cleared flag", {31'd0, ctl_rd_data[0]}, 32'h0);
        check("R9 irq dropped", {31'd0, core_irq}, 32'h0);
        // R7: collision, set wins
        step(1, 4'h3, 0, 4'h0, 1, 2'b11, "dir collide");
        check("R7 set wins", {31'd0, ctl_rd_data[0]}, 32'h1);
        // R10: both sides at once
        step(1, 4'hC, 1, 4'h9, 0, 2'b00, "dir both");
        check("R10 both fields", {24'd0, sem_rd_data}, 32'h9C);
        // R5: host write of zero data still sets flag
        step(0, 4'h0, 0, 4'h0, 1, 2'b01, "dir clr");
        step(1, 4'h0, 0, 4'h0, 0, 2'b00, "dir zero data");
        check("R5 flag on zero write", {31'd0, ctl_rd_data[0]}, 32'h1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[7:4], r[2] & r[3], r[11:8], r[12] & r[13], r[15:14], "rand");
        end

        // R1 again: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        host_wr_en = 1; host_wr_data = 4'hF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        host_wr_en = 0;
        #1;
        check("R1 re-reset word", {24'd0, sem_rd_data}, 32'h0);
        check("R1 re-reset ctl", {30'd0, ctl_rd_data}, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule